// File: doc/BRIEF.md
# Triggered Serial ADC Burst Reader

This block reads a 12-bit serial sampling converter in bursts. A rising edge on the trigger input, usually from a pulse comparator, starts a sequence of conversion frames. In each frame the block pulls chip select low and waits a programmable lead time. It then produces a fixed number of serial clock pulses with the clock idling low, and captures one data bit on each rising clock edge, most significant bit first. The converter shifts its bits out on falling edges, so capturing on the opposite edge avoids any race, and the word lines up without a corrective shift.

The converter returns the result of the previous chip-select cycle in every frame. The block therefore runs one frame more than the number of results it keeps, discards the word from the first frame, and writes the remaining words in order into a small result buffer. A one-cycle done pulse marks a full buffer. A host reads the buffer through a combinational index port. A trigger edge that arrives while a burst is running has no effect on the burst and is counted in a saturating overrun counter.

Top module: `adc_burst_reader`

## Requirements
- R1: A rising edge on trig_i while the block is idle starts a burst of exactly BURST_LEN+1 frames (15 by default). A trigger held high starts only one burst.
- R2: In each frame, cs_n_o goes low and sclk_o stays low for CS_LEAD clock cycles. Then exactly FRAME_BITS sclk_o pulses follow, each high for CLK_DIV cycles and low for CLK_DIV cycles. cs_n_o rises only after the last low phase, and sclk_o is never high while cs_n_o is high.
- R3: sdata_i is captured on each rising sclk_o edge, MSB first. Frame bits 13:12 are the leading bits and bits 11:0 are the result. A buffer entry equals bits 11:0 of its frame with no shift.
- R4: The word from the first frame of a burst is discarded. Buffer entry i holds the word from frame i+1, which is the conversion started at the chip-select fall of frame i.
- R5: done_o is a single-cycle pulse, one per burst, in the cycle after the last entry is written. busy_o is low in that same cycle.
- R6: frame_err_o is set when bit 13 or bit 12 of any kept frame reads 1, and it is cleared when the next burst starts. The leading bits of the discarded frame do not affect it.
- R7: A trigger edge during a burst neither restarts nor changes the burst. It increments ovr_cnt_o, which saturates at 2^OVR_W-1.
- R8: rd_data_o shows buffer entry rd_idx_i combinationally. An index of BURST_LEN or above returns zero.
- R9: After reset, cs_n_o is 1, and sclk_o, busy_o, done_o, frame_err_o, ovr_cnt_o and all buffer entries are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_i | input | 1 | Burst trigger; its rising edge starts a burst (synchronous to clk) |
| sdata_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Active-low chip select to the converter |
| sclk_o | output | 1 | Serial clock, idles low |
| busy_o | output | 1 | High while a burst is running |
| done_o | output | 1 | One-cycle pulse when the buffer holds a full burst |
| frame_err_o | output | 1 | A kept frame had a nonzero leading bit |
| ovr_cnt_o | output | OVR_W | Saturating count of triggers that arrived during a burst |
| rd_idx_i | input | IDX_W ($clog2(BURST_LEN)) | Buffer read index |
| rd_data_o | output | RES_BITS | Buffer entry at rd_idx_i |

## Verification
A slip in the bit counter or the phase counter appears at the ports within the same frame: the number of sclk_o pulses or their widths is wrong, and every later entry of that burst is scaled by a power of two. An off-by-one in the frame counter shows up at done_o time in two ways. Every buffer entry then holds the value of its neighbour, and the frame count on cs_n_o differs from fifteen. A stuck error or overrun register is visible at the next burst boundary, when frame_err_o must clear or ovr_cnt_o must stop at its ceiling.

// File: rtl/adc_burst_pkg.sv
package adc_burst_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_HIGH,
    ST_LOW,
    ST_GAP
  } eng_st_e;

  // saturating increment on a 32-bit view
  function automatic logic [31:0] sat_inc(input logic [31:0] v, input logic [31:0] top);
    return (v >= top) ? v : v + 32'd1;
  endfunction

  // buffer slot for a frame; frame 0 has no slot
  function automatic logic [31:0] slot_of(input logic [31:0] frame);
    return frame - 32'd1;
  endfunction

endpackage

// File: rtl/adc_trig_gate.sv
module adc_trig_gate #(
  parameter int OVR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_i,
  input  logic             busy_i,
  output logic             start_o,
  output logic [OVR_W-1:0] ovr_cnt_o
);
  import adc_burst_pkg::*;

  localparam int OVR_MAX = (1 << OVR_W) - 1;

  logic trig_q;
  logic trig_rise;

  assign trig_rise = trig_i & ~trig_q;
  assign start_o   = trig_rise & ~busy_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q    <= 1'b0;
      ovr_cnt_o <= '0;
    end else begin
      trig_q <= trig_i;
      if (trig_rise && busy_i)
        ovr_cnt_o <= OVR_W'(sat_inc(32'(ovr_cnt_o), 32'(OVR_MAX)));
    end
  end

  // R7
  overrun_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_cnt_o >= $past(ovr_cnt_o));

  // R7
  start_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> !busy_i);

endmodule

// File: rtl/adc_frame_engine.sv
module adc_frame_engine #(
  parameter int FRAME_BITS = 14,
  parameter int RES_BITS   = 12,
  parameter int BURST_LEN  = 14,
  parameter int CLK_DIV    = 2,
  parameter int CS_LEAD    = 3,
  parameter int CS_GAP     = 1,
  parameter int IDX_W      = $clog2(BURST_LEN)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             start_i,
  input  logic                             sdata_i,
  output logic                             cs_n_o,
  output logic                             sclk_o,
  output logic                             busy_o,
  output logic                             wr_en_o,
  output logic [IDX_W-1:0]                 wr_idx_o,
  output logic [RES_BITS-1:0]              wr_res_o,
  output logic [FRAME_BITS-RES_BITS-1:0]   wr_lead_o
);
  import adc_burst_pkg::*;

  localparam int LEAD_W = FRAME_BITS - RES_BITS;
  localparam int FRW    = $clog2(BURST_LEN + 2);
  localparam int BW     = $clog2(FRAME_BITS + 1);
  localparam int CMAX   = (CLK_DIV > CS_LEAD) ? ((CLK_DIV > CS_GAP) ? CLK_DIV : CS_GAP)
                                              : ((CS_LEAD > CS_GAP) ? CS_LEAD : CS_GAP);
  localparam int CW     = $clog2(CMAX + 1);

  eng_st_e               st;
  logic [CW-1:0]         cnt;
  logic [BW-1:0]         bit_cnt;
  logic [FRW-1:0]        frame;
  logic [FRAME_BITS-1:0] shreg;

  // named events for checking
  logic cnt_zero;
  logic sample_ev;
  logic frm_end;
  logic last_frame;

  assign cnt_zero   = (cnt == '0);
  assign frm_end    = (st == ST_LOW) && cnt_zero && (bit_cnt == BW'(FRAME_BITS));
  assign sample_ev  = cnt_zero && ((st == ST_LEAD) ||
                      ((st == ST_LOW) && (bit_cnt != BW'(FRAME_BITS))));
  assign last_frame = (frame == FRW'(BURST_LEN));

  assign cs_n_o = (st == ST_IDLE) || (st == ST_GAP);
  assign sclk_o = (st == ST_HIGH);
  assign busy_o = (st != ST_IDLE);

  assign wr_en_o   = frm_end && (frame != '0);
  assign wr_idx_o  = IDX_W'(slot_of(32'(frame)));
  assign wr_res_o  = shreg[RES_BITS-1:0];
  assign wr_lead_o = shreg[FRAME_BITS-1 -: LEAD_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      bit_cnt <= '0;
      frame   <= '0;
      shreg   <= '0;
    end else begin
      if (sample_ev) begin
        shreg   <= {shreg[FRAME_BITS-2:0], sdata_i};
        bit_cnt <= bit_cnt + 1'b1;
      end
      unique case (st)
        ST_IDLE: if (start_i) begin
          st      <= ST_LEAD;
          cnt     <= CW'(CS_LEAD - 1);
          frame   <= '0;
          bit_cnt <= '0;
        end
        ST_LEAD: if (cnt_zero) begin
          st  <= ST_HIGH;
          cnt <= CW'(CLK_DIV - 1);
        end else cnt <= cnt - 1'b1;
        ST_HIGH: if (cnt_zero) begin
          st  <= ST_LOW;
          cnt <= CW'(CLK_DIV - 1);
        end else cnt <= cnt - 1'b1;
        ST_LOW: if (!cnt_zero) begin
          cnt <= cnt - 1'b1;
        end else if (frm_end) begin
          if (last_frame) st <= ST_IDLE;
          else begin
            st    <= ST_GAP;
            cnt   <= CW'(CS_GAP - 1);
            frame <= frame + 1'b1;
          end
        end else begin
          st  <= ST_HIGH;
          cnt <= CW'(CLK_DIV - 1);
        end
        ST_GAP: if (cnt_zero) begin
          st      <= ST_LEAD;
          cnt     <= CW'(CS_LEAD - 1);
          bit_cnt <= '0;
        end else cnt <= cnt - 1'b1;
        default: st <= ST_IDLE;
      endcase
    end
  end

  // independent count of serial clock rises within a frame
  logic          sclk_q;
  logic [BW-1:0] rise_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q   <= 1'b0;
      rise_cnt <= '0;
    end else begin
      sclk_q <= sclk_o;
      if (cs_n_o) rise_cnt <= '0;
      else if (sclk_o && !sclk_q) rise_cnt <= rise_cnt + 1'b1;
    end
  end

  // R2
  pulses_per_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n_o) |-> (rise_cnt == BW'(FRAME_BITS)));

  // R2
  cs_release_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n_o) |-> !$past(sclk_o));

endmodule

// File: rtl/adc_result_buf.sv
module adc_result_buf #(
  parameter int RES_BITS  = 12,
  parameter int LEAD_W    = 2,
  parameter int BURST_LEN = 14,
  parameter int IDX_W     = $clog2(BURST_LEN)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                wr_en_i,
  input  logic [IDX_W-1:0]    wr_idx_i,
  input  logic [RES_BITS-1:0] wr_res_i,
  input  logic [LEAD_W-1:0]   wr_lead_i,
  input  logic [IDX_W-1:0]    rd_idx_i,
  output logic [RES_BITS-1:0] rd_data_o,
  output logic                done_o,
  output logic                err_o
);
  localparam int WCW = $clog2(BURST_LEN + 1);

  logic [RES_BITS-1:0] mem [BURST_LEN];
  logic                last_wr;

  assign last_wr   = wr_en_i && (32'(wr_idx_i) == BURST_LEN - 1);
  assign rd_data_o = (32'(rd_idx_i) < BURST_LEN) ? mem[rd_idx_i] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < BURST_LEN; i++) mem[i] <= '0;
      done_o <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      done_o <= last_wr;
      if (start_i) err_o <= 1'b0;
      else if (wr_en_i && (wr_lead_i != '0)) err_o <= 1'b1;
      if (wr_en_i) mem[wr_idx_i] <= wr_res_i;
    end
  end

  // write count per burst, kept for the checks
  logic [WCW-1:0] wr_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_cnt <= '0;
    else if (start_i) wr_cnt <= '0;
    else if (wr_en_i) wr_cnt <= wr_cnt + 1'b1;
  end

  // R4
  full_burst_written_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (wr_cnt == WCW'(BURST_LEN)));

  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

endmodule

// File: rtl/adc_burst_reader.sv
module adc_burst_reader #(
  parameter int FRAME_BITS = 14,
  parameter int RES_BITS   = 12,
  parameter int BURST_LEN  = 14,
  parameter int CLK_DIV    = 2,
  parameter int CS_LEAD    = 3,
  parameter int CS_GAP     = 1,
  parameter int OVR_W      = 8,
  parameter int IDX_W      = $clog2(BURST_LEN)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                trig_i,
  input  logic                sdata_i,
  output logic                cs_n_o,
  output logic                sclk_o,
  output logic                busy_o,
  output logic                done_o,
  output logic                frame_err_o,
  output logic [OVR_W-1:0]    ovr_cnt_o,
  input  logic [IDX_W-1:0]    rd_idx_i,
  output logic [RES_BITS-1:0] rd_data_o
);
  localparam int LEAD_W = FRAME_BITS - RES_BITS;

  logic                start;
  logic                wr_en;
  logic [IDX_W-1:0]    wr_idx;
  logic [RES_BITS-1:0] wr_res;
  logic [LEAD_W-1:0]   wr_lead;

  adc_trig_gate #(.OVR_W(OVR_W)) u_gate (
    .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .busy_i(busy_o),
    .start_o(start), .ovr_cnt_o(ovr_cnt_o)
  );

  adc_frame_engine #(
    .FRAME_BITS(FRAME_BITS), .RES_BITS(RES_BITS), .BURST_LEN(BURST_LEN),
    .CLK_DIV(CLK_DIV), .CS_LEAD(CS_LEAD), .CS_GAP(CS_GAP), .IDX_W(IDX_W)
  ) u_eng (
    .clk(clk), .rst_n(rst_n), .start_i(start), .sdata_i(sdata_i),
    .cs_n_o(cs_n_o), .sclk_o(sclk_o), .busy_o(busy_o),
    .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_res_o(wr_res), .wr_lead_o(wr_lead)
  );

  adc_result_buf #(
    .RES_BITS(RES_BITS), .LEAD_W(LEAD_W), .BURST_LEN(BURST_LEN), .IDX_W(IDX_W)
  ) u_buf (
    .clk(clk), .rst_n(rst_n), .start_i(start), .wr_en_i(wr_en),
    .wr_idx_i(wr_idx), .wr_res_i(wr_res), .wr_lead_i(wr_lead),
    .rd_idx_i(rd_idx_i), .rd_data_o(rd_data_o), .done_o(done_o), .err_o(frame_err_o)
  );

  // R5
  idle_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

endmodule

// File: tb/tb_adc_burst_reader.sv
module tb_adc_burst_reader;
  localparam int FB = 14, RB = 12, BL = 14, DIV = 2, LEAD = 3, GAP = 1, OW = 2, IW = 4;
  localparam int NB = 10;

  logic clk = 0, rst_n = 0, trig = 0, sdata = 0;
  logic cs_n, sclk, busy, done, ferr;
  logic [OW-1:0] ovr;
  logic [IW-1:0] rd_idx = '0;
  logic [RB-1:0] rd_data;

  int n_tests = 0, n_fail = 0;

  always #4 clk = ~clk;

  adc_burst_reader #(.FRAME_BITS(FB), .RES_BITS(RB), .BURST_LEN(BL), .CLK_DIV(DIV),
    .CS_LEAD(LEAD), .CS_GAP(GAP), .OVR_W(OW), .IDX_W(IW)) dut (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .sdata_i(sdata), .cs_n_o(cs_n),
    .sclk_o(sclk), .busy_o(busy), .done_o(done), .frame_err_o(ferr),
    .ovr_cnt_o(ovr), .rd_idx_i(rd_idx), .rd_data_o(rd_data));

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // stimulus values per burst b and conversion k
  function automatic int conv_val(input int b, input int k);
    if (b == 0) return (k % 2 == 0) ? 'hAAA : 'h555;
    if (b == 1) return (k < 12) ? (1 << k) : ((k == 12) ? 'hFFF : 0);
    return (b * 977 + k * 293 + 5) & 'hFFF;
  endfunction
  function automatic int conv_lead(input int b, input int k);
    if (b == 3 && k == 5)  return 1;
    if (b == 4 && k == 13) return 2;
    if (b == 6 && k == 14) return 3;
    return 0;
  endfunction

  // converter model: word out belongs to the previous chip-select fall
  int burst_no = 0, conv_k = 0, bitpos = -1;
  logic [FB-1:0] cur_word = '0, out_word = '0;
  always @(negedge cs_n) begin
    out_word = cur_word;
    cur_word = {2'(conv_lead(burst_no, conv_k)), 12'(conv_val(burst_no, conv_k))};
    conv_k++;
    bitpos = FB - 1;
    sdata = out_word[bitpos];
  end
  always @(negedge sclk) begin
    if (!cs_n) begin
      bitpos--;
      sdata = (bitpos >= 0) ? out_word[bitpos] : 1'b0;
    end
  end

  // port-level timing monitor
  logic prev_cs = 1, prev_sclk = 0;
  int rises = 0, lead_cnt = 0, hi_cnt = 0, lo_cnt = 0, frames_seen = 0, mon_bad = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!cs_n && prev_cs) begin rises = 0; lead_cnt = 0; hi_cnt = 0; lo_cnt = 0; end
      if (cs_n && sclk) mon_bad++;
      if (!cs_n) begin
        if (sclk && !prev_sclk) begin
          rises++;
          if (rises == 1 && lead_cnt != LEAD) mon_bad++;
          if (rises > 1 && lo_cnt != DIV) mon_bad++;
          hi_cnt = 0;
        end
        if (!sclk && prev_sclk) begin
          if (hi_cnt != DIV) mon_bad++;
          lo_cnt = 0;
        end
        if (sclk) hi_cnt++;
        else if (rises == 0) lead_cnt++;
        else lo_cnt++;
      end
      if (cs_n && !prev_cs) begin
        frames_seen++;
        if (rises != FB || lo_cnt != DIV) mon_bad++;
      end
    end
    prev_cs = cs_n;
    prev_sclk = sclk;
  end

  bit wd_hit = 0;

  task automatic run_burst(input int b, input bit hold_trig, input int n_ovr);
    int f0 = frames_seen, bad0 = mon_bad, dcount = 0, waited = 0;
    bit seen = 0, busy_at_done = 0, exp_err = 0;
    burst_no = b; conv_k = 0;
    @(negedge clk) trig = 1;
    @(negedge clk); @(negedge clk);
    if (!hold_trig) trig = 0;
    for (int i = 0; i < n_ovr; i++) begin
      @(negedge clk) trig = 1;
      @(negedge clk) trig = 0;
    end
    while (!seen && waited < 4000) begin
      @(negedge clk); waited++;
      if (done) begin seen = 1; dcount++; busy_at_done = busy; end
    end
    if (!seen) wd_hit = 1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (done) dcount++;
    end
    check($sformatf("R1 frames b%0d", b), frames_seen - f0, BL + 1);
    check($sformatf("R2 timing b%0d", b), mon_bad - bad0, 0);
    check($sformatf("R5 done count b%0d", b), dcount, 1);
    check($sformatf("R5 busy at done b%0d", b), int'(busy_at_done), 0);
    for (int i = 0; i < BL; i++) begin
      rd_idx = IW'(i); #1;
      // R3 R4 entry i is conversion i of this burst
      check($sformatf("R3/R4 b%0d e%0d", b, i), int'(rd_data), conv_val(b, i));
      if (conv_lead(b, i) != 0) exp_err = 1;
    end
    check($sformatf("R6 err b%0d", b), int'(ferr), int'(exp_err));
  endtask

  initial begin
    #20;
    // R9 reset state
    check("R9 cs_n", int'(cs_n), 1);
    check("R9 sclk", int'(sclk), 0);
    check("R9 busy", int'(busy), 0);
    check("R9 done", int'(done), 0);
    check("R9 err", int'(ferr), 0);
    check("R9 ovr", int'(ovr), 0);
    check("R9 buf", int'(rd_data), 0);
    @(negedge clk) rst_n = 1;
    repeat (3) @(negedge clk);
    for (int b = 0; b < NB && !wd_hit; b++) begin
      if (b == 5) begin
        run_burst(b, 0, 5);
        // R7 five ignored edges saturate a 2-bit counter at 3
        check("R7 ovr saturate", int'(ovr), 3);
      end else if (b == 7) begin
        run_burst(b, 1, 0);
        // R1 held trigger starts no second burst
        repeat (60) @(negedge clk);
        check("R1 held trig no restart", int'(busy), 0);
        check("R7 ovr unchanged", int'(ovr), 3);
        trig = 0;
      end else run_burst(b, 0, 0);
    end
    // R8 out-of-range index
    rd_idx = 4'd14; #1; check("R8 idx14", int'(rd_data), 0);
    rd_idx = 4'd15; #1; check("R8 idx15", int'(rd_data), 0);
    if (wd_hit) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule